// File: doc/BRIEF.md
# Load/store ordering queue

This block keeps track of memory operations that are in flight and decides, from ordering rules alone, when each of them may issue. Every operation carries an age tag, where a smaller tag means older. At dispatch the operation presents its tag and three flags: may-load, may-store and side-effects. It is then entered into a load queue, a store queue or both. An operation with the side-effect flag becomes a barrier in each queue it enters.

A combinational query port takes a tag and answers whether that operation may issue now. The answer is computed by comparing the queried tag in parallel against every valid entry of both queues. A completion port removes an executed tag from both queues.

Dispatch is governed by an availability status. An operation whose queue is full is refused, and a dispatch attempted while refused raises an error flag one cycle later. A mode input selects whether loads may assume that they never alias older stores.

Top module: `lsq_order`

## Requirements
- R1: A load that is not a barrier is ready whatever older loads are pending. It is not ready while an older barrier entry (load barrier or full barrier) is in the load queue.
- R2: An entry held only in the store queue is ready only when no older entry is in the store queue and no older entry is in the load queue. This holds for either value of `no_alias`.
- R3: When `no_alias` is 1, a load held only in the load queue ignores the store queue. When `no_alias` is 0, it is also not ready while any older entry is in the store queue.
- R4: An accepted dispatch enters the load queue when `disp_may_load` is 1 and the store queue when `disp_may_store` is 1. It takes one entry in each queue it enters, and it is a barrier there when `disp_side_fx` is 1.
- R5: A load barrier is ready only when no older entry is in the load queue, with the store queue treated as in R3. A tag held in both queues is ready only when it is the oldest entry in each queue.
- R6: A queried tag that is in neither queue reports `qry_ready` = 1.
- R7: `avail_status` is 0 for available, 1 for load queue full and 2 for store queue full. The value 1 wins when both apply. An operation with neither may-load nor may-store reports 0.
- R8: A queue counts as full exactly when its occupancy equals its depth parameter (`LQ_DEPTH`, `SQ_DEPTH`). Dispatch is accepted only while the status is 0.
- R9: A dispatch with a non-zero status is not entered. `disp_err` is 1 in the cycle after such a dispatch and 0 after any other cycle.
- R10: A completion removes the tag from both queues at the clock edge, and from that edge on the query reflects the removal. Completing a tag that is not present changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | 1: loads assume no alias with older stores |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Age tag of the dispatched operation |
| disp_may_load | input | 1 | Operation reads memory |
| disp_may_store | input | 1 | Operation writes memory |
| disp_side_fx | input | 1 | Operation has side effects (barrier) |
| avail_status | output | 2 | Availability of the offered operation (R7) |
| disp_err | output | 1 | Registered flag for a refused dispatch |
| qry_tag | input | TAG_W | Tag whose readiness is asked |
| qry_ready | output | 1 | Queried tag may issue |
| done_valid | input | 1 | Completion request |
| done_tag | input | TAG_W | Tag of the executed operation |

## Verification
`avail_status` and `qry_ready` are combinational. The bench therefore samples them one time step after driving the inputs in the low clock phase, before the edge that could change the queues. `disp_err` passes through one register, so it is sampled just after the next rising edge. The effects of a dispatch or a completion on readiness and status appear from that same edge on, and the bench's reference queues are updated at that edge. Directed sequences cover the alias mode, the barriers, full queues and the priority between the two full codes. A long seeded random run then mixes every flag combination with completions of random in-flight tags.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    ST_AVAIL   = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2
  } lsq_status_e;
endpackage

// File: rtl/lsq_tag_queue.sv
module lsq_tag_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             alloc_bar,
  input  logic             clr,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [TAG_W-1:0] qry_tag,
  output logic             full,
  output logic             hit,
  output logic             hit_bar,
  output logic             older_any,
  output logic             older_bar
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] bar;
  logic [TAG_W-1:0] tags [DEPTH];
  logic [CW-1:0]    count;

  logic [DEPTH-1:0] m_clr, m_qry, m_old;
  logic [IW-1:0]    free_idx;

  // one comparator set per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign m_clr[i] = vld[i] && (tags[i] == clr_tag);
    assign m_qry[i] = vld[i] && (tags[i] == qry_tag);
    assign m_old[i] = vld[i] && (tags[i] <  qry_tag);
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign full      = (count == CW'(DEPTH));
  assign hit       = |m_qry;
  assign hit_bar   = |(m_qry & bar);
  assign older_any = |m_old;
  assign older_bar = |(m_old & bar);

  logic clr_hit;
  assign clr_hit = clr && (|m_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      bar   <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr && m_clr[i]) vld[i] <= 1'b0;
        if (alloc && (free_idx == IW'(i))) begin
          vld[i] <= 1'b1;
          bar[i] <= alloc_bar;
        end
      end
      count <= count + CW'(alloc) - CW'(clr_hit);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc && (free_idx == IW'(i))) tags[i] <= alloc_tag;
    end
  end

  // R8: occupancy never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R9: the top never allocates into a full queue
  assert_no_alloc_full_R9: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !full);

  // R10: a completion that hits shrinks occupancy unless an allocation lands
  assert_clear_shrinks_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !alloc) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/lsq_ready_eval.sv
module lsq_ready_eval (
  input  logic no_alias,
  input  logic lq_hit,
  input  logic lq_hit_bar,
  input  logic lq_older_any,
  input  logic lq_older_bar,
  input  logic sq_hit,
  input  logic sq_older_any,
  output logic ready
);
  logic store_clear;
  assign store_clear = no_alias || !sq_older_any;

  always_comb begin
    if (!lq_hit && !sq_hit) begin
      ready = 1'b1;
    end else if (lq_hit && sq_hit) begin
      ready = !lq_older_any && !sq_older_any;
    end else if (lq_hit) begin
      if (lq_hit_bar) ready = !lq_older_any && store_clear;
      else            ready = !lq_older_bar && store_clear;
    end else begin
      ready = !sq_older_any && !lq_older_any;
    end
  end
endmodule

// File: rtl/lsq_order.sv
module lsq_order #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int TAG_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             no_alias,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             disp_may_load,
  input  logic             disp_may_store,
  input  logic             disp_side_fx,
  output logic [1:0]       avail_status,
  output logic             disp_err,
  input  logic [TAG_W-1:0] qry_tag,
  output logic             qry_ready,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag
);
  import lsq_pkg::*;

  logic lq_full, sq_full;
  logic lq_hit, lq_hit_bar, lq_older_any, lq_older_bar;
  logic sq_hit, sq_hit_bar, sq_older_any, sq_older_bar;
  lsq_status_e st;
  logic accept, lq_alloc, sq_alloc, err_q;

  always_comb begin
    if (disp_may_load && lq_full)       st = ST_LQ_FULL;
    else if (disp_may_store && sq_full) st = ST_SQ_FULL;
    else                                st = ST_AVAIL;
  end

  assign accept   = disp_valid && (st == ST_AVAIL) && (disp_may_load || disp_may_store);
  assign lq_alloc = accept && disp_may_load;
  assign sq_alloc = accept && disp_may_store;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= disp_valid && (st != ST_AVAIL);
  end

  assign avail_status = st;
  assign disp_err     = err_q;

  lsq_tag_queue #(.DEPTH(LQ_DEPTH), .TAG_W(TAG_W)) u_lq (
    .clk(clk), .rst(rst),
    .alloc(lq_alloc), .alloc_tag(disp_tag), .alloc_bar(disp_side_fx),
    .clr(done_valid), .clr_tag(done_tag), .qry_tag(qry_tag),
    .full(lq_full), .hit(lq_hit), .hit_bar(lq_hit_bar),
    .older_any(lq_older_any), .older_bar(lq_older_bar)
  );

  lsq_tag_queue #(.DEPTH(SQ_DEPTH), .TAG_W(TAG_W)) u_sq (
    .clk(clk), .rst(rst),
    .alloc(sq_alloc), .alloc_tag(disp_tag), .alloc_bar(disp_side_fx),
    .clr(done_valid), .clr_tag(done_tag), .qry_tag(qry_tag),
    .full(sq_full), .hit(sq_hit), .hit_bar(sq_hit_bar),
    .older_any(sq_older_any), .older_bar(sq_older_bar)
  );

  lsq_ready_eval u_rdy (
    .no_alias(no_alias),
    .lq_hit(lq_hit), .lq_hit_bar(lq_hit_bar),
    .lq_older_any(lq_older_any), .lq_older_bar(lq_older_bar),
    .sq_hit(sq_hit), .sq_older_any(sq_older_any),
    .ready(qry_ready)
  );

  // R7: an operation touching no queue is always available
  assert_nonmem_avail_R7: assert property (@(posedge clk) disable iff (rst)
    (!disp_may_load && !disp_may_store) |-> (avail_status == 2'd0));

  // R9: a refused dispatch is flagged in the next cycle
  assert_err_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && avail_status != 2'd0) |=> disp_err);

  // R2: a store-only entry never reports ready with an older load queued
  assert_store_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (sq_hit && !lq_hit && lq_older_any) |-> !qry_ready);

  // R6: an absent tag is ready
  assert_absent_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (!lq_hit && !sq_hit) |-> qry_ready);

  logic unused_bits;
  assign unused_bits = sq_hit_bar ^ sq_older_bar;
endmodule

// File: tb/tb_lsq_order.sv
module tb_lsq_order;
  localparam int LQD = 8;
  localparam int SQD = 8;
  localparam int TW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic no_alias = 1'b0;
  logic disp_valid = 1'b0;
  logic [TW-1:0] disp_tag = '0;
  logic disp_may_load = 1'b0, disp_may_store = 1'b0, disp_side_fx = 1'b0;
  logic [1:0] avail_status;
  logic disp_err;
  logic [TW-1:0] qry_tag = '0;
  logic qry_ready;
  logic done_valid = 1'b0;
  logic [TW-1:0] done_tag = '0;

  always #5 clk = ~clk;

  lsq_order #(.LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .no_alias(no_alias),
    .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
    .disp_side_fx(disp_side_fx), .avail_status(avail_status),
    .disp_err(disp_err), .qry_tag(qry_tag), .qry_ready(qry_ready),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  int checks = 0;
  int errors = 0;
  int nt = 1;
  int last_done = 0;

  // reference queues
  bit mlv [LQD]; int mlt [LQD]; bit mlb [LQD];
  bit msv [SQD]; int mst [SQD]; bit msb [SQD];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lcount();
    int c = 0;
    for (int i = 0; i < LQD; i++) if (mlv[i]) c++;
    return c;
  endfunction

  function automatic int scount();
    int c = 0;
    for (int i = 0; i < SQD; i++) if (msv[i]) c++;
    return c;
  endfunction

  function automatic int exp_status(bit ml, bit ms);
    if (ml && lcount() == LQD) return 1;
    if (ms && scount() == SQD) return 2;
    return 0;
  endfunction

  function automatic int find_l(int t);
    for (int i = 0; i < LQD; i++) if (mlv[i] && mlt[i] == t) return i;
    return -1;
  endfunction

  function automatic int find_s(int t);
    for (int i = 0; i < SQD; i++) if (msv[i] && mst[i] == t) return i;
    return -1;
  endfunction

  function automatic bit exp_ready(int t, bit na);
    int il = find_l(t);
    int is = find_s(t);
    bit l_old = 0, l_oldb = 0, s_old = 0;
    for (int i = 0; i < LQD; i++)
      if (mlv[i] && mlt[i] < t) begin l_old = 1; if (mlb[i]) l_oldb = 1; end
    for (int i = 0; i < SQD; i++)
      if (msv[i] && mst[i] < t) s_old = 1;
    if (il < 0 && is < 0) return 1;
    if (il >= 0 && is >= 0) return !l_old && !s_old;
    if (il >= 0) begin
      if (mlb[il]) return !l_old && (na || !s_old);
      return !l_oldb && (na || !s_old);
    end
    return !s_old && !l_old;
  endfunction

  function automatic string rlabel(int t);
    int il = find_l(t);
    int is = find_s(t);
    if (t == last_done && il < 0 && is < 0) return "R10 ready after completion";
    if (il < 0 && is < 0) return "R6 absent tag";
    if (il >= 0 && is >= 0) return "R5 both-queue op";
    if (il >= 0 && mlb[il]) return "R5 load barrier";
    if (il >= 0) return "R1 R3 load";
    return "R2 store";
  endfunction

  task automatic step(bit dv, bit ml, bit ms, bit sf, bit dn, int dt, int qt, bit na);
    int es;
    bit eerr;
    @(negedge clk);
    disp_valid = dv; disp_tag = TW'(nt);
    disp_may_load = ml; disp_may_store = ms; disp_side_fx = sf;
    done_valid = dn; done_tag = TW'(dt);
    qry_tag = TW'(qt); no_alias = na;
    #1;
    es = exp_status(ml, ms);
    if (dv) chk("R4 R7 R8 status", int'(avail_status), es);
    chk(rlabel(qt), int'(qry_ready), int'(exp_ready(qt, na)));
    @(posedge clk);
    eerr = dv && (es != 0);
    if (dv && es == 0 && (ml || ms)) begin
      if (ml) for (int i = 0; i < LQD; i++)
        if (!mlv[i]) begin mlv[i] = 1; mlt[i] = nt; mlb[i] = sf; break; end
      if (ms) for (int i = 0; i < SQD; i++)
        if (!msv[i]) begin msv[i] = 1; mst[i] = nt; msb[i] = sf; break; end
    end
    if (dn) begin
      for (int i = 0; i < LQD; i++) if (mlv[i] && mlt[i] == dt) mlv[i] = 0;
      for (int i = 0; i < SQD; i++) if (msv[i] && mst[i] == dt) msv[i] = 0;
      last_done = dt;
    end
    if (dv) nt++;
    #1;
    chk("R9 disp_err", int'(disp_err), int'(eerr));
  endtask

  task automatic drain();
    for (int k = 0; k < LQD + SQD + 2; k++) begin
      int t = 0;
      for (int i = 0; i < LQD; i++) if (mlv[i]) t = mlt[i];
      for (int i = 0; i < SQD; i++) if (msv[i]) t = mst[i];
      if (t != 0) step(0, 0, 0, 0, 1, t, t, 0);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1;
    void'($urandom(32'd4711));
    for (int i = 0; i < LQD; i++) mlv[i] = 0;
    for (int i = 0; i < SQD; i++) msv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state
    disp_may_load = 1; disp_may_store = 1; qry_tag = 16'd77;
    #1;
    chk("R7 status after reset", int'(avail_status), 0);
    chk("R9 disp_err after reset", int'(disp_err), 0);
    chk("R6 absent tag after reset", int'(qry_ready), 1);

    // R3: load behind a store, both alias modes
    t0 = nt; step(1, 0, 1, 0, 0, 0, 0, 0);
    t1 = nt; step(1, 1, 0, 0, 0, 0, t1, 0);
    step(0, 0, 0, 0, 0, 0, t1, 0);
    chk("R3 load waits on older store", int'(qry_ready), 0);
    step(0, 0, 0, 0, 0, 0, t1, 1);
    chk("R3 load passes store in no-alias mode", int'(qry_ready), 1);
    step(0, 0, 0, 0, 1, t0, t1, 0);
    step(0, 0, 0, 0, 0, 0, t1, 0);
    chk("R10 load ready once store removed", int'(qry_ready), 1);
    drain();

    // R1/R5: load barrier in front of a load
    t0 = nt; step(1, 1, 0, 1, 0, 0, 0, 1);
    t1 = nt; step(1, 1, 0, 0, 0, 0, t0, 1);
    step(0, 0, 0, 0, 0, 0, t1, 1);
    chk("R1 load blocked by older barrier", int'(qry_ready), 0);
    // full barrier behind the load
    step(1, 1, 1, 1, 0, 0, t1, 1);
    step(0, 0, 0, 0, 0, 0, t1 + 1, 1);
    chk("R5 full barrier not oldest", int'(qry_ready), 0);
    drain();

    // R7/R8: fill the load queue, then refuse
    for (int k = 0; k < LQD; k++) step(1, 1, 0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0, 0, 1);
    chk("R9 error after refused load", int'(disp_err), 1);
    for (int k = 0; k < SQD; k++) step(1, 0, 1, 0, 0, 0, 0, 1);
    step(1, 1, 1, 1, 0, 0, 0, 1);
    chk("R7 load-full code wins", int'(avail_status), 1);
    step(1, 0, 1, 0, 0, 0, 0, 1);
    chk("R7 store-full code", int'(avail_status), 2);
    step(1, 0, 0, 1, 0, 0, 0, 1);
    chk("R7 non-memory op available", int'(avail_status), 0);
    step(0, 0, 0, 0, 1, 16'hFFF0, 0, 1);
    drain();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      int tl [LQD + SQD];
      int n = 0;
      int dt = 0, qt;
      bit dn;
      bit dv = ($urandom_range(0, 99) < 55);
      bit ml = $urandom_range(0, 1);
      bit ms = $urandom_range(0, 1);
      bit sf = ($urandom_range(0, 3) == 0);
      bit na = $urandom_range(0, 1);
      for (int i = 0; i < LQD; i++) if (mlv[i]) begin tl[n] = mlt[i]; n++; end
      for (int i = 0; i < SQD; i++) if (msv[i]) begin tl[n] = mst[i]; n++; end
      dn = (n > 0) && ($urandom_range(0, 99) < 40);
      if (dn) dt = tl[$urandom_range(0, n - 1)];
      case ($urandom_range(0, 5))
        0: qt = last_done;
        1: qt = nt + 3;
        default: qt = (n > 0) ? tl[$urandom_range(0, n - 1)] : nt;
      endcase
      step(dv, ml, ms, sf, dn, dt, qt, na);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule